// File: doc/BRIEF.md
# Activate-Once Watchdog Timer

This block is a software-fault watchdog. Its core is a 7-bit down-counter that steps once per prescaler period, plus a single activation flag. After any reset the flag is clear and the counter is idle. Software writes an 8-bit control word:

- The low seven bits reload the counter.
- A one in the top bit arms the watchdog. Once armed, only a reset disarms it. A later write with the top bit clear leaves it armed.

While armed, the counter must be reloaded before its bit 6 reaches zero. When it does reach zero, the block issues a one-cycle reset request. On the next clock the counter and the flag return to their reset values. The timeout therefore depends on the reload value:

- Reloading 7Fh (control word FFh) gives the longest timeout, 64 prescaler periods.
- Reloading 40h (control word C0h) gives the shortest timeout, one period.
- Any reload with bit 6 clear requests a reset almost at once.

Top module: `latched_watchdog`

## Requirements
- R1: While rst_n is low at a clock edge, the next readback is 7Fh (flag clear, counter 7Fh) and wdg_rst is low.
- R2: A write loads wr_data[6:0] into the counter. The new value appears on rd_data[6:0] in the cycle after the write edge. A write on the edge where a pulse is already high is ignored.
- R3: A write with wr_data[7]=1 sets the flag, which reads back as rd_data[7]. A write with wr_data[7]=0 never clears it. Only rst_n or a watchdog pulse clears it.
- R4: While the flag is clear, the counter does not change except by writes.
- R5: The prescaler counts system clocks from reset, and also from the end of each pulse. It produces one step every PRESCALE clocks. While the flag is set, each step decrements the counter by one.
- R6: wdg_rst goes high on the clock edge that follows any cycle in which the flag is set and counter bit 6 is 0. This covers both a decrement from 40h to 3Fh and a write whose bit 6 is 0.
- R7: wdg_rst lasts exactly one cycle. In the following cycle the readback is 7Fh and the prescaler restarts from zero.
- R8: If a write and a prescaler step fall on the same edge, the written value is kept and no decrement is applied.
- R9: After writing FFh with no further writes, the pulse occurs after 64 prescaler steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word: bit 7 arms, bits 6:0 reload the counter |
| wdg_rst | output | 1 | One-cycle watchdog reset request |
| rd_data | output | 8 | Readback: {flag, counter} |

## Verification
The bench drives several situations and compares every cycle against a behavioural model:

- A write with bit 7 clear to an armed watchdog. A design that let software disarm it would drop rd_data[7] and never time out.
- A reload landing on the exact edge of a prescaler step. A design that let the step win would read back one less than written.
- An arming write of 80h. A design that only watched for a decrement from 40h would sit armed at 00h and fire 64 steps late, or never.
- The cycle after each pulse. A design with a stretched pulse, or one that forgets to reset the counter, flag or prescaler phase, would miscompare there.

// File: rtl/wdg_pkg.sv
// Package: shared constants and the control word layout of the watchdog.
// Assumes an 8-bit control word with the arm flag in the top bit.
package wdg_pkg;
    localparam int unsigned CNT_W = 7;
    localparam logic [CNT_W-1:0] CNT_RESET = 7'h7F;

    typedef struct packed {
        logic             arm;
        logic [CNT_W-1:0] count;
    } wdg_ctrl_t;
endpackage

// File: rtl/wdg_prescaler.sv
// Module: divides the system clock by PRESCALE and emits one-cycle steps.
// Assumes PRESCALE >= 2. The divider restarts on reset and on a restart request.
module wdg_prescaler #(
    parameter int unsigned PRESCALE = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic step
);
    localparam int unsigned PS_W = $clog2(PRESCALE);
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    logic [PS_W-1:0] div_q;

    assign step = (div_q == PS_LAST);

    // Advance the divider, wrapping at the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else if (step) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_countdown.sv
// Module: holds the arm flag and the 7-bit down-counter.
// Assumes a write has priority over a step. The flag can only be cleared by
// reset or by the trip restart.
module wdg_countdown
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic             wr_en,
    input  wdg_ctrl_t        wr_word,
    output wdg_ctrl_t        state
);
    logic             arm_q;
    logic [CNT_W-1:0] cnt_q;

    assign state.arm   = arm_q;
    assign state.count = cnt_q;

    // Arm flag: set-only from software.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            arm_q <= 1'b0;
        end else if (wr_en && wr_word.arm) begin
            arm_q <= 1'b1;
        end
    end

    // Counter: reload on write, else decrement on a step while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= CNT_RESET;
        end else if (wr_en) begin
            cnt_q <= wr_word.count;
        end else if (arm_q && step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdg_trip.sv
// Module: raises a one-cycle reset request when the armed counter has bit 6 clear.
// Assumes the request itself restarts the rest of the block, so it self-clears.
module wdg_trip
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wdg_ctrl_t state,
    output logic      trip
);
    logic trip_q;

    assign trip = trip_q;

    // Register the expiry condition; never hold it for two cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_q <= 1'b0;
        end else begin
            trip_q <= state.arm && !state.count[CNT_W-1] && !trip_q;
        end
    end
endmodule

// File: rtl/latched_watchdog.sv
// Module: top of the activate-once watchdog. It ties together the prescaler,
// the counter and the trip logic.
// Assumes a synchronous active-low reset and a single writer of the control word.
module latched_watchdog
    import wdg_pkg::*;
#(
    parameter int unsigned PRESCALE = 12288
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       wdg_rst,
    output logic [7:0] rd_data
);
    logic      step;
    logic      trip;
    wdg_ctrl_t state;
    wdg_ctrl_t wr_word;

    assign wr_word = wdg_ctrl_t'(wr_data);

    wdg_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (trip),
        .step    (step)
    );

    wdg_countdown u_countdown (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (trip),
        .step    (step),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .state   (state)
    );

    wdg_trip u_trip (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .trip  (trip)
    );

    assign wdg_rst = trip;
    assign rd_data = state;
endmodule

// File: rtl/latched_watchdog_chk.sv
// Checker: port-level temporal properties of latched_watchdog, bound into every instance.
module latched_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       wdg_rst,
    input logic [7:0] rd_data
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'h7F && !wdg_rst));

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdg_rst) |=> (rd_data[6:0] == $past(wr_data[6:0])));

    assert_arm_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7] && !wdg_rst) |=> rd_data[7]);

    assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !wdg_rst) |=> rd_data[7]);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && !wr_en && !wdg_rst) |=> $stable(rd_data[6:0]));

    assert_trip_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !rd_data[6] && !wdg_rst) |=> wdg_rst);

    assert_trip_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdg_rst) |-> $past(rd_data[7]));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst |=> (!wdg_rst && rd_data == 8'h7F));
endmodule

bind latched_watchdog latched_watchdog_chk i_chk (.*);

// File: tb/test_latched_watchdog.sv
// Bench: behavioural reference model compared with the design on every clock.
module test_latched_watchdog;
    localparam int P = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wdg_rst;
    logic [7:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";

    // model state
    int m_ps = 0, m_cnt = 127, m_arm = 0, m_fire = 0;

    latched_watchdog #(.PRESCALE(P)) i_latched_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wdg_rst(wdg_rst), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    // Reference model: next state computed from the requirements.
    always @(posedge clk) begin
        if (!rst_n || m_fire != 0) begin
            m_ps = 0; m_cnt = 127; m_arm = 0; m_fire = 0;
        end else begin
            int nf;
            int tick;
            nf   = (m_arm != 0 && m_cnt < 64) ? 1 : 0;
            tick = (m_ps == P - 1) ? 1 : 0;
            m_ps = (tick != 0) ? 0 : m_ps + 1;
            if (wr_en) begin
                m_cnt = wr_data & 8'h7F;
                if (wr_data[7]) m_arm = 1;
            end else if (m_arm != 0 && tick != 0) begin
                m_cnt = (m_cnt + 127) % 128;
            end
            m_fire = nf;
        end
    end

    // Compare design outputs with the model away from the active edge.
    always @(negedge clk) begin
        int exp_rd;
        exp_rd = m_arm * 128 + m_cnt;
        vectors++;
        if (rd_data !== 8'(exp_rd)) begin
            errors++;
            $display("FAIL %s rd_data actual=%02h expected=%02h", cur_req, rd_data, exp_rd);
        end
        if (wdg_rst !== (m_fire != 0)) begin
            errors++;
            $display("FAIL %s wdg_rst actual=%0b expected=%0d", cur_req, wdg_rst, m_fire);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(input int limit);
        int n = 0;
        while (!wdg_rst && n < limit) begin
            @(negedge clk); n++;
        end
        vectors++;
        if (!wdg_rst) begin
            errors++;
            $display("FAIL %s pulse actual=0 expected=1 within %0d cycles", cur_req, limit);
        end
    endtask

    initial begin
        fork
            begin
                cur_req = "R1";
                idle(3);
                rst_n = 1'b1;
                idle(2);
                cur_req = "R4";
                idle(5 * P);
                cur_req = "R2";
                wr(8'h55);
                idle(3 * P);
                cur_req = "R3";
                wr(8'hC5);
                wr(8'h60);
                idle(2 * P);
                cur_req = "R8";
                @(negedge clk);
                while (m_ps != P - 1) @(negedge clk);
                wr_en = 1'b1; wr_data = 8'h70;
                @(negedge clk);
                wr_en = 1'b0;
                cur_req = "R5";
                idle(4 * P);
                cur_req = "R6";
                wait_pulse(60 * P);
                cur_req = "R7";
                idle(3);
                cur_req = "R6";
                wr(8'h80);
                idle(4);
                cur_req = "R6";
                wr(8'h3F);
                idle(2 * P);
                wr(8'h80);
                idle(4);
                cur_req = "R9";
                wr(8'hFF);
                wait_pulse(66 * P);
                cur_req = "R7";
                idle(P + 3);
                cur_req = "R1";
                rst_n = 1'b0;
                idle(2);
                rst_n = 1'b1;
                idle(2);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule